// File: doc/BRIEF.md
# Cellular-Automaton Scan Self-Test Engine

This block runs a logic self-test over a bank of parallel scan chains. A one-dimensional linear cellular automaton (CA) made of rule-90 and rule-150 cells supplies stimulus. It has one cell per chain, and each cell drives only its own chain. A multiple-input signature register (MISR) compacts the responses. It also has one stage per chain, and each stage takes the scan-out bit of one chain.

A sequencer runs the test. It shifts a full pattern into every chain, pulses capture for one cycle, and repeats this for a programmed number of patterns. It then shifts the chains out once more to unload the last response, and raises a done flag. The flag stays high until the next start. The final signature can then be read and compared with a known-good value.

Sequencer states: `ST_IDLE`, `ST_SHIFT`, `ST_CAPT`, `ST_UNLOAD` and `ST_DONE`. Its transitions are:
- `ST_IDLE`→`ST_SHIFT` on start.
- `ST_SHIFT`→`ST_CAPT` after the last of CHAIN_LEN shift cycles.
- `ST_CAPT`→`ST_SHIFT` while more patterns remain.
- `ST_CAPT`→`ST_UNLOAD` after the final capture.
- `ST_UNLOAD`→`ST_DONE` after CHAIN_LEN cycles.
- `ST_DONE`→`ST_SHIFT` on start.

Top module: `cabist_engine`

## Requirements
- R1: On every cycle with `scan_en` high, `chain_si` is the CA state, and the CA then steps. Each cell i becomes the XOR of cell i-1 and cell i+1, with a zero standing in beyond either end. When bit i of `RULE150` is 1, cell i's own value is XORed in as well.
- R2: With 4 chains and `RULE150` = 4'b1010, the CA visits all 15 nonzero states before it repeats.
- R3: An accepted start loads `seed` into the CA. A seed of zero loads the value 1 instead (bit 0 set), so `chain_si` is never zero.
- R4: The CA holds its state on every cycle without `scan_en`, apart from a seed load.
- R5: On every cycle with `scan_en` high, the signature becomes (signature shifted left by one) XOR (`MISR_TAPS` if the old top bit was 1) XOR `chain_so`. Bit i of `chain_so` enters stage i.
- R6: The signature does not change on cycles without `scan_en`. Asserting `sig_clear` sets it to zero on the next edge, and this has priority over any update. Start does not clear it.
- R7: After a start is accepted, the engine runs P passes. Each pass is CHAIN_LEN cycles with `scan_en` high, then one cycle with `capture` high. A final CHAIN_LEN unload cycles follow, then `done` rises. P is `pat_count` as sampled at start, with zero treated as 1.
- R8: `scan_en` and `capture` are never high together, and both stay low while `done` is high.
- R9: `done` stays high until start. A start in `ST_DONE` begins a new run. A start while the engine is busy is ignored.
- R10: After reset, `scan_en`, `capture`, `done` and the signature are 0, and `chain_si` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (accepted in idle or done) |
| seed | input | N_CHAINS | CA starting state |
| pat_count | input | PAT_W | Number of patterns |
| sig_clear | input | 1 | Zero the signature |
| chain_so | input | N_CHAINS | Scan-out bit of each chain |
| chain_si | output | N_CHAINS | Scan-in bit for each chain |
| scan_en | output | 1 | Chains shift this cycle |
| capture | output | 1 | Chains capture this cycle |
| signature | output | N_CHAINS | MISR contents |
| done | output | 1 | Run complete |

## Verification
The assertions assume that `start` is a single-cycle pulse from the controller. They also assume that `sig_clear` is used only while the engine is idle or done; a clear in mid-run is legal but would break the expected signature. The stimulus therefore pulses start only from the idle or done states, with one deliberate pulse in mid-run to show that it is ignored. It also asserts `sig_clear` only in the done state.

The bench models the scan chains itself and feeds back the bits the engine sent in. It sweeps every 4-bit seed against pattern counts 0 to 3, so the expected stimulus and signature follow arithmetically from R1 and R5.

// File: rtl/cabist_pkg.sv
package cabist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPT,
        ST_UNLOAD,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/ca_prpg.sv
module ca_prpg #(
    parameter int          N       = 80,
    parameter logic [N-1:0] RULE150 = {(N/2){2'b10}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] seed,
    input  logic         step,
    output logic [N-1:0] state
);

    localparam logic [N-1:0] SEED_DEFAULT = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] cur;
    logic [N-1:0] nxt;
    logic [N-1:0] seed_ok;

    assign seed_ok = (seed == '0) ? SEED_DEFAULT : seed;

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic lft;
        logic rgt;
        if (i == 0) begin : g_lo
            assign lft = 1'b0;
        end else begin : g_lin
            assign lft = cur[i-1];
        end
        if (i == N-1) begin : g_hi
            assign rgt = 1'b0;
        end else begin : g_rin
            assign rgt = cur[i+1];
        end
        if (RULE150[i]) begin : g_r150
            assign nxt[i] = lft ^ cur[i] ^ rgt;
        end else begin : g_r90
            assign nxt[i] = lft ^ rgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= SEED_DEFAULT;
        end else if (load) begin
            cur <= seed_ok;
        end else if (step) begin
            cur <= nxt;
        end
    end

    assign state = cur;

endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
    parameter int           N    = 80,
    parameter logic [N-1:0] TAPS = {{(N-2){1'b0}}, 2'b11}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [N-1:0] din,
    output logic [N-1:0] sig
);

    logic [N-1:0] acc;
    logic [N-1:0] fb;
    logic [N-1:0] nxt;

    assign fb  = {N{acc[N-1]}} & TAPS;
    assign nxt = {acc[N-2:0], 1'b0} ^ fb ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (en) begin
            acc <= nxt;
        end
    end

    assign sig = acc;

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import cabist_pkg::*;
#(
    parameter int LEN   = 64,
    parameter int PAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PAT_W-1:0] pat_count,
    output logic             load,
    output logic             scan_en,
    output logic             capture,
    output logic             done
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] SHIFT_LAST = CW'(LEN - 1);

    seq_state_t       st_q;
    seq_state_t       st_d;
    logic [CW-1:0]    shift_cnt;
    logic [PAT_W-1:0] pat_cnt;
    logic [PAT_W-1:0] pat_lim;
    logic             shifting;
    logic             last_shift;
    logic             last_pat;
    logic             accept;

    assign shifting   = (st_q == ST_SHIFT) || (st_q == ST_UNLOAD);
    assign last_shift = (shift_cnt == SHIFT_LAST);
    assign last_pat   = ({1'b0, pat_cnt} + (PAT_W+1)'(1)) >= {1'b0, pat_lim};
    assign accept     = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_SHIFT;
            ST_SHIFT:  if (last_shift) st_d = ST_CAPT;
            ST_CAPT:   st_d = last_pat ? ST_UNLOAD : ST_SHIFT;
            ST_UNLOAD: if (last_shift) st_d = ST_DONE;
            ST_DONE:   if (start) st_d = ST_SHIFT;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_cnt <= '0;
            pat_cnt   <= '0;
            pat_lim   <= PAT_W'(1);
        end else begin
            if (shifting && !last_shift) begin
                shift_cnt <= shift_cnt + CW'(1);
            end else begin
                shift_cnt <= '0;
            end
            if (accept) begin
                pat_cnt <= '0;
                pat_lim <= (pat_count == '0) ? PAT_W'(1) : pat_count;
            end else if (st_q == ST_CAPT) begin
                pat_cnt <= pat_cnt + PAT_W'(1);
            end
        end
    end

    always_comb begin
        load    = 1'b0;
        scan_en = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        unique case (st_q)
            ST_IDLE:   load = start;
            ST_SHIFT:  scan_en = 1'b1;
            ST_CAPT:   capture = 1'b1;
            ST_UNLOAD: scan_en = 1'b1;
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cabist_engine.sv
module cabist_engine #(
    parameter int                  N_CHAINS  = 80,
    parameter int                  CHAIN_LEN = 64,
    parameter int                  PAT_W     = 12,
    parameter logic [N_CHAINS-1:0] RULE150   = {(N_CHAINS/2){2'b10}},
    parameter logic [N_CHAINS-1:0] MISR_TAPS = {{(N_CHAINS-2){1'b0}}, 2'b11}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N_CHAINS-1:0] seed,
    input  logic [PAT_W-1:0]    pat_count,
    input  logic                sig_clear,
    input  logic [N_CHAINS-1:0] chain_so,
    output logic [N_CHAINS-1:0] chain_si,
    output logic                scan_en,
    output logic                capture,
    output logic [N_CHAINS-1:0] signature,
    output logic                done
);

    logic load;

    bist_seq #(
        .LEN   (CHAIN_LEN),
        .PAT_W (PAT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pat_count (pat_count),
        .load      (load),
        .scan_en   (scan_en),
        .capture   (capture),
        .done      (done)
    );

    ca_prpg #(
        .N       (N_CHAINS),
        .RULE150 (RULE150)
    ) u_prpg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .seed  (seed),
        .step  (scan_en),
        .state (chain_si)
    );

    sig_misr #(
        .N    (N_CHAINS),
        .TAPS (MISR_TAPS)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sig_clear),
        .en    (scan_en),
        .din   (chain_so),
        .sig   (signature)
    );

endmodule

// File: rtl/cabist_chk.sv
module cabist_chk #(
    parameter int N = 80
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sig_clear,
    input logic         scan_en,
    input logic         capture,
    input logic         done,
    input logic [N-1:0] chain_si,
    input logic [N-1:0] signature
);

    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_si != '0);

    p_ca_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !start) |=> $stable(chain_si));

    p_sig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !sig_clear) |=> $stable(signature));

    p_sig_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sig_clear |=> (signature == '0));

    p_capt_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> scan_en);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capture));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !capture));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind cabist_engine cabist_chk #(.N(N_CHAINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sig_clear (sig_clear),
    .scan_en   (scan_en),
    .capture   (capture),
    .done      (done),
    .chain_si  (chain_si),
    .signature (signature)
);

// File: tb/sim_cabist_engine.sv
module sim_cabist_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int CL = 3;
    localparam int PW = 4;
    localparam logic [NC-1:0] MASK = 4'b1010;
    localparam logic [NC-1:0] TAPS = 4'b0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NC-1:0] seed = '0;
    logic [PW-1:0] pat_count = '0;
    logic          sig_clear = 1'b0;
    logic [NC-1:0] chain_so = '0;
    logic [NC-1:0] chain_si;
    logic          scan_en;
    logic          capture;
    logic [NC-1:0] signature;
    logic          done;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [NC-1:0] exp_sig = '0;
    logic [NC-1:0] exp_ca;
    logic [CL-1:0] ch [NC];
    logic [NC-1:0] ca_log [64];
    int            n_log;

    cabist_engine #(
        .N_CHAINS  (NC),
        .CHAIN_LEN (CL),
        .PAT_W     (PW),
        .RULE150   (MASK),
        .MISR_TAPS (TAPS)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seed      (seed),
        .pat_count (pat_count),
        .sig_clear (sig_clear),
        .chain_so  (chain_so),
        .chain_si  (chain_si),
        .scan_en   (scan_en),
        .capture   (capture),
        .signature (signature),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NC-1:0] ca_next(input logic [NC-1:0] s);
        return (s << 1) ^ (s >> 1) ^ (s & MASK);
    endfunction

    function automatic logic [NC-1:0] misr_next(input logic [NC-1:0] s, input logic [NC-1:0] d);
        return (s << 1) ^ (s[NC-1] ? TAPS : '0) ^ d;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic run_case(input logic [NC-1:0] sd, input int pc, input bit glitch);
        int p;
        int cycles;
        int nshift;
        int ncapt;
        bit si_bad;
        bit sig_bad;
        logic [NC-1:0] held;
        p = (pc == 0) ? 1 : pc;
        cycles = 0; nshift = 0; ncapt = 0; si_bad = 0; sig_bad = 0; n_log = 0;
        @(negedge clk);
        seed = sd; pat_count = PW'(pc); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_ca = (sd == '0) ? NC'(1) : sd;
        while (!done && cycles < 1000) begin
            for (int i = 0; i < NC; i++) chain_so[i] = ch[i][CL-1];
            if (signature !== exp_sig) sig_bad = 1;
            if (scan_en) begin
                if (chain_si !== exp_ca) si_bad = 1;
                if (n_log < 64) begin ca_log[n_log] = chain_si; n_log++; end
                exp_sig = misr_next(exp_sig, chain_so);
                for (int i = 0; i < NC; i++) ch[i] = {ch[i][CL-2:0], chain_si[i]};
                exp_ca = ca_next(exp_ca);
                nshift++;
            end
            if (capture) begin
                ncapt++;
                for (int i = 0; i < NC; i++) ch[i] = {ch[i][0], ch[i][CL-1:1]} ^ CL'(i + 5);
            end
            start = (glitch && cycles == 4) ? 1'b1 : 1'b0;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        chk(!si_bad, "R1 stimulus follows CA rule", int'(si_bad), 0);
        chk(!sig_bad, "R5 running signature", int'(sig_bad), 0);
        chk(ncapt == p, "R7 capture count", ncapt, p);
        chk(nshift == (p + 1) * CL, "R7 shift count", nshift, (p + 1) * CL);
        chk(cycles == (p + 1) * CL + p, glitch ? "R9 busy start ignored" : "R7 run length",
            cycles, (p + 1) * CL + p);
        chk(signature === exp_sig, "R5 final signature", int'(signature), int'(exp_sig));
        held = signature;
        for (int k = 0; k < 3; k++) begin
            chain_so = ~chain_so;
            @(negedge clk);
        end
        chk(signature === held && done === 1'b1, "R6 R9 signature and done hold",
            int'(signature), int'(held));
    endtask

    initial begin
        for (int i = 0; i < NC; i++) ch[i] = CL'(i);
        #(3 * CLK_PERIOD);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_en === 1'b0 && capture === 1'b0 && done === 1'b0, "R10 reset controls",
            int'({scan_en, capture, done}), 0);
        chk(signature === '0, "R10 reset signature", int'(signature), 0);
        chk(chain_si === NC'(1), "R10 reset CA state", int'(chain_si), 1);

        // R3: zero seed substitutes 1
        run_case('0, 1, 0);
        chk(ca_log[0] === NC'(1), "R3 zero seed replaced", int'(ca_log[0]), 1);

        // R2: full period of 15 with 4 cells
        run_case(NC'(1), 5, 0);
        begin
            int dup;
            dup = 0;
            for (int a = 0; a < 15; a++) begin
                if (ca_log[a] == '0) dup++;
                for (int b = a + 1; b < 15; b++) if (ca_log[a] == ca_log[b]) dup++;
            end
            chk(dup == 0, "R2 15 distinct nonzero states", dup, 0);
            chk(ca_log[15] === ca_log[0], "R2 period closes at 15", int'(ca_log[15]), int'(ca_log[0]));
        end

        // R6: clear in done
        @(negedge clk);
        sig_clear = 1'b1;
        @(negedge clk);
        sig_clear = 1'b0;
        exp_sig = '0;
        chk(signature === '0, "R6 clear zeroes signature", int'(signature), 0);

        // R9: start during run ignored
        run_case(4'b0110, 2, 1);

        // near-exhaustive sweep, restarting from done each time (R9, R3, R4)
        for (int s = 0; s < 16; s++) begin
            for (int pc = 0; pc < 4; pc++) begin
                run_case(NC'(s), pc, 0);
            end
        end
        finish_run();
    end

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

endmodule